// File: doc/BRIEF.md
# Triggered Serial Clock Burst Generator

This block acts as the clock master for a serial converter readout. It waits for the converter's active-low sample-ready line to fall. It then drives a burst with a fixed number of serial clock pulses. The same clock line feeds the converter's serial output and a downstream receiver that runs as a clock follower, so each burst paces exactly one word transfer. Outside a burst the clock line stays low.

The ready line is asynchronous. It passes through a synchroniser chain, and only a high-to-low transition starts a burst. A transition that arrives while a burst is still running is dropped. The serial clock toggles every `HALF_PER` system cycles. With the default of one, the serial clock runs at half the system clock, so an 80 MHz system clock gives a 40 MHz serial clock. A 16-pulse burst then finishes well inside half of a 1 µs sample period.

An internal shift register samples the serial data line on the chosen edge of the generated clock, most significant bit first, and presents the assembled word. When the last pulse ends, a one-cycle done strobe marks the word as complete.

Top module: `spi_burst_gen`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, the block is idle after that edge: `sclk_o` = 0, `busy_o` = 0, `done_o` = 0, `word_o` = 0.
- R2: A high-to-low transition of `rdy_n_i` starts a burst. If `rdy_n_i` changes between clock edges, `busy_o` is first high after the third rising `clk` edge that follows the change (two synchroniser stages plus the start register).
- R3: Holding `rdy_n_i` low after a burst has ended starts no further burst. Only a new falling transition does.
- R4: Each burst has exactly `BITS` (default 16) pulses on `sclk_o`. Each high and each low phase lasts `HALF_PER` (default 1) `clk` cycles. The first rise comes `HALF_PER` cycles after `busy_o` goes high.
- R5: `sclk_o` is low whenever `busy_o` is low. Every burst ends with `sclk_o` low, so no partial pulse is left.
- R6: `sdata_i` is sampled at the `clk` edge where `sclk_o` goes high (default `CAPTURE_ON_RISE`=1). Bits enter most significant first (default `MSB_FIRST`=1), so the first bit sampled in a burst ends up at `word_o[BITS-1]`.
- R7: `done_o` is high for exactly one `clk` cycle, starting at the edge where the last pulse falls. `busy_o` is still high during that cycle. `word_o` holds the full word and stays stable. `busy_o` falls at the next edge. A default burst keeps `busy_o` high for 2·`BITS`·`HALF_PER`+1 = 33 cycles, which is 412.5 ns at 80 MHz.
- R8: A falling transition of `rdy_n_i` that arrives while `busy_o` is high has no effect. The burst keeps its pulse count, and no second burst follows.
- R9: Asserting `rst` in the middle of a burst returns the block to idle at the next edge, with the clock low and the counters cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rdy_n_i | input | 1 | Asynchronous sample-ready line from the converter, active low |
| sdata_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Generated serial clock, idles low |
| busy_o | output | 1 | High from burst start until the cycle after done |
| done_o | output | 1 | One-cycle strobe when the word is complete |
| word_o | output | BITS | Assembled received word |

## Verification
The checker assumes that `rdy_n_i` stays at each level for at least a few system cycles, so the synchroniser sees every transition. It also assumes that `sdata_i` is settled before each capture edge. The bench changes the ready line only on falling `clk` edges and holds each level for several cycles. Its converter model changes the data line only on falling system edges after each observed serial clock rise, so each bit is stable one full cycle before it is captured. The pulse-count and single-cycle-done properties also rely on reset asserting for only whole cycles, and the bench drives reset only on falling edges.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } sbg_state_e;
endpackage

// File: rtl/sbg_sync_fall.sv
module sbg_sync_fall #(
   parameter int STAGES   = 2,
   parameter bit IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic async_i,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sbg_sync_fall: STAGES must be at least 2");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain_q[gi] <= IDLE_LVL;
               else     chain_q[gi] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain_q[gi] <= IDLE_LVL;
               else     chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) prev_q <= IDLE_LVL;
      else     prev_q <= chain_q[STAGES-1];
   end

   assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/sbg_seq.sv
module sbg_seq
   import sbg_pkg::*;
#(
   parameter int BITS     = 16,
   parameter int HALF_PER = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   output logic sclk_o,
   output logic rise_stb_o,
   output logic fall_stb_o,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = $clog2(BITS + 1);
   localparam int HW = $clog2(HALF_PER + 1);

   sbg_state_e    state_q;
   logic [CW-1:0] pcnt_q;
   logic [HW-1:0] hcnt_q;
   logic          sclk_q;
   logic          tick;
   logic          last;

   assign tick       = (hcnt_q == HW'(HALF_PER - 1));
   assign last       = (pcnt_q == CW'(BITS - 1));
   assign rise_stb_o = (state_q == ST_RUN) && tick && !sclk_q;
   assign fall_stb_o = (state_q == ST_RUN) && tick &&  sclk_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         pcnt_q  <= '0;
         hcnt_q  <= '0;
         sclk_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               sclk_q <= 1'b0;
               hcnt_q <= '0;
               pcnt_q <= '0;
               if (start_i) state_q <= ST_RUN;
            end
            ST_RUN: begin
               if (tick) hcnt_q <= '0;
               else      hcnt_q <= hcnt_q + 1'b1;
               if (rise_stb_o) sclk_q <= 1'b1;
               if (fall_stb_o) begin
                  sclk_q <= 1'b0;
                  if (last) state_q <= ST_DONE;
                  else      pcnt_q  <= pcnt_q + 1'b1;
               end
            end
            ST_DONE: begin
               state_q <= ST_IDLE;
               pcnt_q  <= '0;
               hcnt_q  <= '0;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sclk_o = sclk_q;
   assign busy_o = (state_q != ST_IDLE);
   assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/sbg_shift.sv
module sbg_shift #(
   parameter int BITS      = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en_i,
   input  logic            din_i,
   output logic [BITS-1:0] word_o
);
   logic [BITS-1:0] sr_q;

   generate
      if (MSB_FIRST) begin : g_msb
         always_ff @(posedge clk) begin
            if (rst)       sr_q <= '0;
            else if (en_i) sr_q <= {sr_q[BITS-2:0], din_i};
         end
      end else begin : g_lsb
         always_ff @(posedge clk) begin
            if (rst)       sr_q <= '0;
            else if (en_i) sr_q <= {din_i, sr_q[BITS-1:1]};
         end
      end
   endgenerate

   assign word_o = sr_q;
endmodule

// File: rtl/spi_burst_gen.sv
module spi_burst_gen #(
   parameter int BITS            = 16,
   parameter int HALF_PER        = 1,
   parameter int SYNC_STAGES     = 2,
   parameter bit CAPTURE_ON_RISE = 1'b1,
   parameter bit MSB_FIRST       = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            rdy_n_i,
   input  logic            sdata_i,
   output logic            sclk_o,
   output logic            busy_o,
   output logic            done_o,
   output logic [BITS-1:0] word_o
);
   generate
      if (BITS < 2) begin : g_bad_bits
         $error("spi_burst_gen: BITS must be at least 2");
      end
      if (HALF_PER < 1) begin : g_bad_half
         $error("spi_burst_gen: HALF_PER must be at least 1");
      end
   endgenerate

   logic start;
   logic rise_stb;
   logic fall_stb;
   logic cap_stb;

   sbg_sync_fall #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_i (rdy_n_i),
      .fall_o  (start)
   );

   sbg_seq #(.BITS(BITS), .HALF_PER(HALF_PER)) u_seq (
      .clk        (clk),
      .rst        (rst),
      .start_i    (start),
      .sclk_o     (sclk_o),
      .rise_stb_o (rise_stb),
      .fall_stb_o (fall_stb),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );

   generate
      if (CAPTURE_ON_RISE) begin : g_cap_rise
         assign cap_stb = rise_stb;
      end else begin : g_cap_fall
         assign cap_stb = fall_stb;
      end
   endgenerate

   sbg_shift #(.BITS(BITS), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk    (clk),
      .rst    (rst),
      .en_i   (cap_stb),
      .din_i  (sdata_i),
      .word_o (word_o)
   );
endmodule

// File: rtl/sbg_checker.sv
module sbg_checker #(
   parameter int BITS = 16
) (
   input logic            clk,
   input logic            rst,
   input logic            sclk_o,
   input logic            busy_o,
   input logic            done_o,
   input logic [BITS-1:0] word_o
);
   int unsigned rises_q;
   logic        sclk_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         rises_q <= 0;
         sclk_d  <= 1'b0;
      end else begin
         sclk_d <= sclk_o;
         if (!busy_o)               rises_q <= 0;
         else if (sclk_o && !sclk_d) rises_q <= rises_q + 1;
      end
   end

   assert_idle_clock_low_R5: assert property (@(posedge clk) disable iff (rst)
      !busy_o |-> !sclk_o);

   assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   assert_done_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (busy_o && !sclk_o));

   assert_word_stable_R7: assert property (@(posedge clk) disable iff (rst)
      done_o |-> $stable(word_o));

   assert_busy_ends_after_done_R7: assert property (@(posedge clk) disable iff (rst)
      ($fell(busy_o) && !$past(rst)) |-> $past(done_o));

   assert_pulse_count_R4: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (rises_q == BITS));

   assert_rise_in_burst_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(sclk_o) |-> busy_o);
endmodule

bind spi_burst_gen sbg_checker #(.BITS(BITS)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .sclk_o (sclk_o),
   .busy_o (busy_o),
   .done_o (done_o),
   .word_o (word_o)
);

// File: tb/sim_spi_burst_gen.sv
module sim_spi_burst_gen;
   localparam time CLK_PER  = 12.5ns;
   localparam int  BITS     = 16;
   localparam int  SYNC_LAT = 3;
   localparam int  DONE_K   = SYNC_LAT + 2 * BITS;
   localparam int  NVEC     = 6;
   localparam logic [BITS-1:0] VEC [NVEC] = '{
      16'hA5C3, 16'h0000, 16'hFFFF, 16'h8001, 16'h7FFE, 16'h1234
   };

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            rdy_n_i = 1'b1;
   logic            sdata_i = 1'b0;
   logic            sclk_o;
   logic            busy_o;
   logic            done_o;
   logic [BITS-1:0] word_o;

   int              n_chk = 0;
   int              n_err = 0;
   logic [BITS-1:0] cur_word = '0;
   bit              finished = 1'b0;

   always #(CLK_PER / 2) clk = ~clk;

   spi_burst_gen u0 (
      .clk(clk), .rst(rst), .rdy_n_i(rdy_n_i), .sdata_i(sdata_i),
      .sclk_o(sclk_o), .busy_o(busy_o), .done_o(done_o), .word_o(word_o)
   );

   // converter model: next bit presented after each observed clock rise
   initial begin
      int  idx = 0;
      logic sclk_q = 1'b0;
      forever begin
         @(negedge clk);
         if (!busy_o) idx = 0;
         else if (sclk_o && !sclk_q) idx++;
         sclk_q  = sclk_o;
         sdata_i = (idx < BITS) ? cur_word[BITS-1-idx] : 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // glitch_at > 0: ready line goes high at that cycle and falls again 6 later
   task automatic run_burst(input logic [BITS-1:0] w, input int glitch_at,
                            input int hold_low);
      int first_busy = -1, done_k = -1, n_done = 0, rises = 0, highs = 0;
      int busy_end = -1, idle_hi = 0;
      logic prev_s = 1'b0;
      logic [BITS-1:0] w_done = '0;
      @(negedge clk);
      cur_word = w;
      rdy_n_i  = 1'b0;
      for (int k = 1; k <= DONE_K + 6; k++) begin
         @(negedge clk);
         if (glitch_at > 0 && k == glitch_at)     rdy_n_i = 1'b1;
         if (glitch_at > 0 && k == glitch_at + 6) rdy_n_i = 1'b0;
         if (busy_o && first_busy < 0) first_busy = k;
         if (!busy_o && first_busy > 0 && busy_end < 0) busy_end = k;
         if (sclk_o) highs++;
         if (sclk_o && !prev_s) rises++;
         if (sclk_o && !busy_o) idle_hi++;
         prev_s = sclk_o;
         if (done_o) begin
            n_done++;
            if (done_k < 0) begin done_k = k; w_done = word_o; end
         end
      end
      chk(first_busy == SYNC_LAT, "R2", "busy start cycle", first_busy, SYNC_LAT);
      chk(rises == BITS, "R4", "clock rises", rises, BITS);
      chk(highs == BITS, "R4", "clock high cycles", highs, BITS);
      chk(idle_hi == 0, "R5", "clock high while idle", idle_hi, 0);
      chk(done_k == DONE_K, "R7", "done cycle", done_k, DONE_K);
      chk(n_done == 1, "R7", "done count", n_done, 1);
      chk(busy_end == DONE_K + 1, "R7", "busy end cycle", busy_end, DONE_K + 1);
      chk(w_done == w, "R6", "word at done", w_done, w);
      for (int k = 0; k < hold_low; k++) begin
         @(negedge clk);
         chk(!busy_o && !sclk_o, (glitch_at > 0) ? "R8" : "R3",
             "no restart while ready low", busy_o, 0);
      end
      chk(word_o == w, "R7", "word held after burst", word_o, w);
      rdy_n_i = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      fork
         begin
            #(CLK_PER * 200000);
            if (!finished) begin
               n_err++;
               $display("FAIL watchdog expired");
               $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
               $finish;
            end
         end
      join_none

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!sclk_o && !busy_o && !done_o, "R1", "idle outputs in reset",
          {sclk_o, busy_o, done_o}, 0);
      chk(word_o == '0, "R1", "word in reset", word_o, 0);
      rst = 1'b0;
      repeat (4) @(negedge clk);

      // vector table: R2 R4 R5 R6 R7
      for (int i = 0; i < NVEC; i++) run_burst(VEC[i], 0, 2);

      // R3: ready held low for a long time after the burst
      run_burst(16'h5A5A, 0, 60);

      // R8: a fresh falling edge in the middle of a burst is dropped
      run_burst(16'hC0DE, 8, 40);

      // R9: reset in the middle of a burst
      @(negedge clk);
      cur_word = 16'hBEEF;
      rdy_n_i  = 1'b0;
      repeat (12) @(negedge clk);
      chk(busy_o, "R9", "burst running before reset", busy_o, 1);
      rst = 1'b1;
      @(negedge clk);
      chk(!sclk_o && !busy_o && !done_o, "R9", "idle after mid-burst reset",
          {sclk_o, busy_o, done_o}, 0);
      chk(word_o == '0, "R9", "word cleared by reset", word_o, 0);
      rst = 1'b0;
      rdy_n_i = 1'b1;
      repeat (6) @(negedge clk);
      chk(!busy_o, "R9", "stays idle after reset release", busy_o, 0);

      // burst after reset works normally
      run_burst(16'h0F0F, 0, 2);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule